// File: doc/BRIEF.md
# External Interrupt Request Flag Register

This block watches eight active-low external request pins and turns them into interrupt flags. Software sees the flags in a 16-bit status register on a simple synchronous bus. The bus has an address, a read strobe, a write strobe, write data and registered read data. Every pin has its own 2-bit sense-select code, supplied from outside. The code makes the pin either a live low-level request or a sticky latch that fires on a falling edge, a rising edge or both edges.

Each pin first passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one cycle earlier. The block drives one request output per pin, equal to that pin's flag, towards the interrupt-handling logic. It accepts one acknowledge pulse per pin back from that logic.

A latched flag can be cleared in two ways. Software can clear it, but only after it has read the flag as 1. The handler can clear it with its acknowledge pulse. A new edge in the same cycle as a clear keeps the flag set. Priority, vectoring, masking and the register that stores the sense-select codes belong to other blocks.

Top module: `ext_req_flags`

## Requirements
- R1: After reset every flag, every request output and the read data are 0.
- R2: Register bits 15 to 8 always read as 0, and writes to them change nothing.
- R3: With sense code 00 (low level), flag n is 1 while pin n is low and 0 while it is high. A pin change shows on the flag 3 clock edges later, and bus writes do not affect the flag.
- R4: With sense code 01 (falling edge), 10 (rising edge) or 11 (both edges), flag n is set 3 clock edges after the selected transition on pin n. The flag stays set after the pin returns to its previous level.
- R5: In an edge mode, writing 0 to bit n at the flag address clears flag n only if a read at that address since the last clear returned bit n as 1. The clear uses up that permission. A 0-write without such a read has no effect.
- R6: Writing 1 to a flag bit never sets the flag.
- R7: In an edge mode, an acknowledge pulse on ack line n clears flag n on the next clock edge, with no earlier read needed.
- R8: When a selected edge on pin n and a clear of flag n (0-write or acknowledge) fall on the same clock edge, the flag stays 1.
- R9: Request output n always equals flag n. A read returns the flags in bits 7 to 0, with bit n holding flag n.
- R10: Read data appears on the clock edge that samples the read strobe and is 0 in every other cycle. Reads of any address other than the flag address (0) return 0, and writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinN | input | 8 | External request pins, active low, asynchronous |
| senseSel | input | 16 | Sense code per pin; bits 2n+1:2n belong to pin n |
| ackIn | input | 8 | Per-pin acknowledge pulse from the handler |
| reqOut | output | 8 | Per-pin interrupt request (equals the flag) |
| busAddr | input | 4 | Register address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |

## Verification
A pin change passes through two synchronizer flops and the flag register, so every flag result is due on the third rising edge after the pin moves. The bench drives the pin on a falling edge, waits exactly three falling edges and checks there. One check also samples one cycle early to show the flag is not yet set. Bus writes and acknowledges act on the one rising edge inside their pulse, and read data is registered on that same edge, so those results are sampled on the next falling edge. The same-edge race is built by placing the clear two falling edges after the pin change, so that it lands on the edge where the new transition is registered.

// File: rtl/ext_req_pkg.sv
package ext_req_pkg;

  // Per-pin sense codes
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  // Strobes from bus decode to the flag datapath
  typedef struct packed {
    logic rdHit;
    logic wrHit;
  } strobe_t;

endpackage

// File: rtl/ext_req_ctrl.sv
module ext_req_ctrl
  import ext_req_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [NUM_PINS-1:0] flags,
  output strobe_t             stb,
  output logic [REG_W-1:0]    busRdata
);

  localparam int PAD_W = REG_W - NUM_PINS;

  logic addrHit;

  always_comb begin
    addrHit   = (busAddr == FLAG_ADDR);
    stb.rdHit = busRd & addrHit;
    stb.wrHit = busWr & addrHit;
  end

  // Read data is registered and returns to zero outside read cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (stb.rdHit) begin
      busRdata <= {{PAD_W{1'b0}}, flags};
    end else begin
      busRdata <= '0;
    end
  end

endmodule

// File: rtl/ext_req_dpath.sv
module ext_req_dpath
  import ext_req_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SYNC_W   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinN,
  input  logic [2*NUM_PINS-1:0] senseSel,
  input  logic [NUM_PINS-1:0]   ackIn,
  input  logic [NUM_PINS-1:0]   wrBits,
  input  strobe_t               stb,
  output logic [NUM_PINS-1:0]   flags
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // Synchronizer chain; idles high so reset produces no edge
    logic [SYNC_W-1:0] syncReg;
    logic              pinSync;
    logic              pinPrev;
    logic              riseSeen;
    logic              fallSeen;
    logic              edgeHit;
    logic              wrClr;
    logic              clrAny;
    logic              flagR;
    logic              armedR;
    sense_e            mode;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncReg <= '1;
        pinPrev <= 1'b1;
      end else begin
        syncReg <= {syncReg[SYNC_W-2:0], pinN[i]};
        pinPrev <= pinSync;
      end
    end

    always_comb begin
      pinSync  = syncReg[SYNC_W-1];
      mode     = sense_e'(senseSel[2*i +: 2]);
      riseSeen = pinSync & ~pinPrev;
      fallSeen = ~pinSync & pinPrev;
      unique case (mode)
        SENSE_FALL: edgeHit = fallSeen;
        SENSE_RISE: edgeHit = riseSeen;
        SENSE_BOTH: edgeHit = riseSeen | fallSeen;
        default:    edgeHit = 1'b0;
      endcase
      wrClr  = stb.wrHit & ~wrBits[i] & armedR;
      clrAny = wrClr | ackIn[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagR  <= 1'b0;
        armedR <= 1'b0;
      end else if (mode == SENSE_LOW) begin
        flagR  <= ~pinSync;
        armedR <= 1'b0;
      end else begin
        // A fresh edge outranks any clear on the same edge
        if (edgeHit) begin
          flagR <= 1'b1;
        end else if (clrAny) begin
          flagR <= 1'b0;
        end
        if (clrAny) begin
          armedR <= 1'b0;
        end else if (stb.rdHit && flagR) begin
          armedR <= 1'b1;
        end
      end
    end

    assign flags[i] = flagR;
  end

endmodule

// File: rtl/ext_req_flags.sv
module ext_req_flags
  import ext_req_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 4,
  parameter int SYNC_W   = 2,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinN,
  input  logic [2*NUM_PINS-1:0] senseSel,
  input  logic [NUM_PINS-1:0]   ackIn,
  output logic [NUM_PINS-1:0]   reqOut,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busRd,
  input  logic                  busWr,
  input  logic [REG_W-1:0]      busWdata,
  output logic [REG_W-1:0]      busRdata
);

  strobe_t             stb;
  logic [NUM_PINS-1:0] flags;

  ext_req_ctrl #(
    .NUM_PINS (NUM_PINS),
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W),
    .FLAG_ADDR(FLAG_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .flags   (flags),
    .stb     (stb),
    .busRdata(busRdata)
  );

  ext_req_dpath #(
    .NUM_PINS(NUM_PINS),
    .SYNC_W  (SYNC_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .pinN    (pinN),
    .senseSel(senseSel),
    .ackIn   (ackIn),
    .wrBits  (busWdata[NUM_PINS-1:0]),
    .stb     (stb),
    .flags   (flags)
  );

  assign reqOut = flags;

endmodule

// File: rtl/ext_req_chk.sv
module ext_req_chk #(
  parameter int NUM_PINS = 8,
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = '0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_PINS-1:0]   pinN,
  input logic [2*NUM_PINS-1:0] senseSel,
  input logic [NUM_PINS-1:0]   ackIn,
  input logic [NUM_PINS-1:0]   reqOut,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busRd,
  input logic [REG_W-1:0]      busRdata
);

  // Track how long each pin has held its level (saturating at 3)
  logic [NUM_PINS-1:0] pinSeen;
  logic [1:0]          quietCnt [NUM_PINS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSeen <= '1;
      for (int i = 0; i < NUM_PINS; i++) quietCnt[i] <= 2'd0;
    end else begin
      pinSeen <= pinN;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (pinN[i] != pinSeen[i]) quietCnt[i] <= 2'd0;
        else if (quietCnt[i] != 2'd3) quietCnt[i] <= quietCnt[i] + 2'd1;
      end
    end
  end

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[REG_W-1:NUM_PINS] == '0);

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> busRdata == '0);

  // R9
  read_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == FLAG_ADDR) |=> busRdata[NUM_PINS-1:0] == $past(reqOut));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (senseSel[2*i +: 2] == 2'b00 && quietCnt[i] == 2'd3)
      |=> reqOut[i] == !$past(pinSeen[i]));

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ackIn[i] && senseSel[2*i +: 2] != 2'b00 && quietCnt[i] == 2'd3)
      |=> !reqOut[i]);

    // R6
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!reqOut[i] && senseSel[2*i +: 2] != 2'b00 && quietCnt[i] == 2'd3)
      |=> !reqOut[i]);
  end

endmodule

bind ext_req_flags ext_req_chk #(
  .NUM_PINS (NUM_PINS),
  .REG_W    (REG_W),
  .ADDR_W   (ADDR_W),
  .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pinN    (pinN),
  .senseSel(senseSel),
  .ackIn   (ackIn),
  .reqOut  (reqOut),
  .busAddr (busAddr),
  .busRd   (busRd),
  .busRdata(busRdata)
);

// File: tb/ext_req_flags_test.sv
`timescale 1ns/1ps
module ext_req_flags_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pinN = 8'hFF;
  logic [15:0] senseSel = '0;
  logic [7:0]  ackIn = '0;
  logic [7:0]  reqOut;
  logic [3:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  ext_req_flags uut (
    .clk(clk), .rstN(rstN), .pinN(pinN), .senseSel(senseSel),
    .ackIn(ackIn), .reqOut(reqOut), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busRead(input logic [3:0] addr, output logic [15:0] data);
    busAddr = addr; busRd = 1'b1;
    @(negedge clk);
    data = busRdata;
    busRd = 1'b0;
  endtask

  task automatic busWrite(input logic [3:0] addr, input logic [15:0] data);
    busAddr = addr; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic setMode(input int pin, input logic [1:0] code);
    senseSel[2*pin +: 2] = code;
  endtask

  task automatic t_reset();
    check("R1 reqOut", {8'h0, reqOut}, 16'h0000);
    check("R1 rdata", busRdata, 16'h0000);
  endtask

  task automatic t_level();
    logic [15:0] rd;
    pinN[3] = 1'b0;
    cyc(2);
    check("R3 not before 3 edges", {8'h0, reqOut}, 16'h0000);
    cyc(1);
    check("R3 low sets", {8'h0, reqOut}, 16'h0008);
    busRead(4'h0, rd);
    busWrite(4'h0, 16'h0000);
    cyc(1);
    check("R3 write ignored", {8'h0, reqOut}, 16'h0008);
    pinN[3] = 1'b1;
    cyc(3);
    check("R3 high clears", {8'h0, reqOut}, 16'h0000);
  endtask

  task automatic t_fall();
    logic [15:0] rd;
    setMode(0, 2'b01);
    cyc(1);
    pinN[0] = 1'b0;
    cyc(3);
    check("R4 falling sets", {8'h0, reqOut}, 16'h0001);
    pinN[0] = 1'b1;
    cyc(3);
    check("R4 sticky", {8'h0, reqOut}, 16'h0001);
    busWrite(4'h0, 16'h0000);
    check("R5 unarmed write", {8'h0, reqOut}, 16'h0001);
    busRead(4'h0, rd);
    check("R9 read flags", rd, 16'h0001);
    busWrite(4'h3, 16'h0000);
    check("R10 other addr write", {8'h0, reqOut}, 16'h0001);
    busWrite(4'h0, 16'h0000);
    check("R5 armed write clears", {8'h0, reqOut}, 16'h0000);
    busWrite(4'h0, 16'hFFFF);
    cyc(1);
    check("R6 one-write no set", {8'h0, reqOut}, 16'h0000);
  endtask

  task automatic t_rise();
    setMode(1, 2'b10);
    cyc(1);
    pinN[1] = 1'b0;
    cyc(3);
    check("R4 rising ignores fall", {8'h0, reqOut}, 16'h0000);
    pinN[1] = 1'b1;
    cyc(3);
    check("R4 rising sets", {8'h0, reqOut}, 16'h0002);
    ackIn[1] = 1'b1;
    cyc(1);
    ackIn[1] = 1'b0;
    check("R7 ack clears rise flag", {8'h0, reqOut}, 16'h0000);
  endtask

  task automatic t_both();
    setMode(2, 2'b11);
    cyc(1);
    pinN[2] = 1'b0;
    cyc(3);
    check("R4 both fall sets", {8'h0, reqOut}, 16'h0004);
    ackIn[2] = 1'b1;
    cyc(1);
    ackIn[2] = 1'b0;
    check("R7 ack clears", {8'h0, reqOut}, 16'h0000);
    pinN[2] = 1'b1;
    cyc(3);
    check("R4 both rise sets", {8'h0, reqOut}, 16'h0004);
    ackIn[2] = 1'b1;
    cyc(1);
    ackIn[2] = 1'b0;
  endtask

  task automatic t_race();
    logic [15:0] rd;
    setMode(5, 2'b11);
    cyc(1);
    pinN[5] = 1'b0;
    cyc(3);
    busRead(4'h0, rd);
    check("R9 pin5 read", rd, 16'h0020);
    pinN[5] = 1'b1;
    cyc(2);
    busAddr = 4'h0; busWdata = 16'h0000; busWr = 1'b1; ackIn[5] = 1'b1;
    cyc(1);
    busWr = 1'b0; ackIn[5] = 1'b0;
    check("R8 edge beats clear", {8'h0, reqOut}, 16'h0020);
    ackIn[5] = 1'b1;
    cyc(1);
    ackIn[5] = 1'b0;
    check("R7 later ack clears", {8'h0, reqOut}, 16'h0000);
  endtask

  task automatic t_upper();
    logic [15:0] rd;
    pinN[7] = 1'b0;
    cyc(3);
    busWrite(4'h0, 16'hFF00);
    busRead(4'h0, rd);
    check("R2 upper zero", rd, 16'h0080);
    busRead(4'h5, rd);
    check("R10 other addr reads zero", rd, 16'h0000);
    cyc(1);
    check("R10 idle rdata zero", busRdata, 16'h0000);
    pinN[7] = 1'b1;
    cyc(3);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rstN = 1'b1;
    cyc(2);
    t_reset();
    t_level();
    t_fall();
    t_rise();
    t_both();
    t_race();
    t_upper();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule